// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the control unit for a five-stage in-order pipeline made up of fetch, decode with register read, execute, memory access and write-back. Each cycle it reads the register numbers that the instructions in decode and execute use as sources. It also reads the destination, write-enable and load flags of the instructions further down the pipeline, and a taken-branch indication that is resolved in the memory stage. From these it sets the operand bypass selects for both execute inputs. It also decides whether the front end must hold, whether a no-op is injected behind decode, and which younger stages are squashed when a branch redirects fetch.

The block has no state of its own. All outputs are combinational functions of the current pipeline-register contents, and the datapath applies them at the next clock edge. The register file writes before it reads within a cycle, so a source that matches only the write-back destination needs neither a bypass into decode nor a stall. Register 0 is hard-wired and never produces a dependency.

Top module: `hazard_ctrl`

## Requirements
- R1: Operand selects use a 2-bit code: 2'b00 register-file value, 2'b01 result held in the memory/write-back register, 2'b10 result held in the execute/memory register. Code 2'b11 never appears. A non-load instruction in the memory stage whose enabled, nonzero destination equals an execute source gives 2'b10 for that operand.
- R2: When the memory stage does not supply an operand, an enabled, nonzero write-back destination equal to that execute source gives 2'b01. This holds whether the write-back instruction is a load or an ALU operation.
- R3: When both the memory stage and the write-back stage hold a valid matching destination for the same source, the select is 2'b10, the younger result.
- R4: A load in the memory stage is never a bypass source. Its match falls through to the write-back check, or to 2'b00.
- R5: A destination of 0 or a cleared write-enable never causes a bypass (select 2'b00) and never causes a stall.
- R6: A load in execute with an enabled, nonzero destination that equals either decode source raises `stall` and `bubble_idex` together for that cycle, when no branch is taken.
- R7: A non-load instruction in execute never causes a stall, and neither does a load whose destination matches no decode source.
- R8: A decode source that matches only the write-back destination causes no stall.
- R9: A taken branch in the memory stage raises `pc_redirect`, `flush_ifid`, `flush_idex` and `flush_exmem`. All four are low when no branch is taken.
- R10: When a taken branch and a load-use dependency occur in the same cycle, the flush wins: `stall` and `bubble_idex` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_rs1 | input | AW | First source register of the instruction in execute |
| ex_rs2 | input | AW | Second source register of the instruction in execute |
| ex_rd | input | AW | Destination of the instruction in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination held in the execute/memory register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Destination held in the memory/write-back register |
| wb_we | input | 1 | Write-back instruction writes a register |
| mem_br_taken | input | 1 | Branch in the memory stage is taken |
| fwd_a | output | 2 | Bypass select for the first execute operand |
| fwd_b | output | 2 | Bypass select for the second execute operand |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble_idex | output | 1 | Load a no-op into the decode/execute register |
| flush_ifid | output | 1 | Squash the instruction entering the fetch/decode register |
| flush_idex | output | 1 | Squash the instruction entering the decode/execute register |
| flush_exmem | output | 1 | Squash the instruction entering the execute/memory register |
| pc_redirect | output | 1 | Next fetch uses the branch target |

## Verification
The assertions check on every evaluation that only legal select codes appear. They also check that a 2'b10 or 2'b01 select always points at an enabled producer with a nonzero matching destination, that a load in the memory stage is never picked, that stall and bubble move together, and that a taken branch suppresses both. Which select is expected for a given combination, and whether a real load-use dependency is detected, can only be shown by the bench. It sweeps every combination of a four-register subset over the sources, destinations, enables, load flags and branch outcome. That sweep covers back-to-back ALU pairs, load followed by use, load followed by an independent instruction, write-back-only matches, and taken and not-taken branches.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the hazard controller.
// Assumes a two-source register format for every instruction.
package hz_pkg;
    // Bypass select code; the datapath operand muxes decode these values.
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/hz_fwd_unit.sv
`timescale 1ns/1ps
// Bypass select for a single execute operand.
// Picks the execute/memory result first, because it is the younger one.
// Loads in the memory stage are skipped, since their data is not ready yet.
// Assumes register 0 is constant and never needs a bypass.
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output fwd_sel_e      sel
);
    logic mem_hit;
    logic wb_hit;

    // Qualify each producer: enabled, nonzero destination, equal to the source.
    always_comb begin
        mem_hit = mem_we && !mem_is_load && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_we && (wb_rd != '0) && (wb_rd == src);
    end

    // Priority choice, younger producer first.
    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
    end
endmodule

// File: rtl/hz_load_use.sv
`timescale 1ns/1ps
// Detects a decode instruction that reads the destination of a load in execute.
// The load data exists only after the memory stage, so such a pair must be
// held apart by one cycle. Assumes decode sources are always treated as used.
module hz_load_use #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0][AW-1:0] id_src,
    input  logic [AW-1:0]           ex_rd,
    input  logic                    ex_we,
    input  logic                    ex_is_load,
    output logic                    hazard
);
    logic             producer_ok;
    logic [NSRC-1:0]  src_hit;

    // A load that writes a real register is the only producer considered.
    always_comb producer_ok = ex_is_load && ex_we && (ex_rd != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Compare one decode source against the load destination.
        always_comb src_hit[i] = (id_src[i] == ex_rd);
    end

    // A hazard needs a valid load and at least one matching source.
    always_comb hazard = producer_ok && (|src_hit);
endmodule

// File: rtl/hz_flow_ctrl.sv
`timescale 1ns/1ps
// Turns the load-use and taken-branch conditions into pipeline register
// controls. A taken branch squashes the three younger stages and wins over
// a load-use hold, because the held instruction is discarded anyway.
module hz_flow_ctrl (
    input  logic load_use,
    input  logic br_taken,
    output logic stall,
    output logic bubble_idex,
    output logic flush_ifid,
    output logic flush_idex,
    output logic flush_exmem,
    output logic pc_redirect
);
    // Hold the front end and inject a no-op only when no redirect happens.
    always_comb begin
        stall       = load_use && !br_taken;
        bubble_idex = load_use && !br_taken;
    end

    // A redirect squashes the fetch, decode and execute occupants.
    always_comb begin
        pc_redirect = br_taken;
        flush_ifid  = br_taken;
        flush_idex  = br_taken;
        flush_exmem = br_taken;
    end
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
// Hazard and bypass controller for a five-stage in-order pipeline.
// Purely combinational; the outputs take effect at the next clock edge of the
// datapath. Assumes the register file writes before it reads, so decode never
// needs a bypass from write-back.
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic          mem_br_taken,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          stall,
    output logic          bubble_idex,
    output logic          flush_ifid,
    output logic          flush_idex,
    output logic          flush_exmem,
    output logic          pc_redirect
);
    logic [NUM_SRC-1:0][AW-1:0] ex_src;
    logic [NUM_SRC-1:0][AW-1:0] id_src;
    fwd_sel_e                   fwd_sel [NUM_SRC];
    logic                       load_use;

    // Gather the operand numbers so each operand gets an identical slice.
    always_comb begin
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
        id_src[0] = id_rs1;
        id_src[1] = id_rs2;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
        hz_fwd_unit #(.AW(AW)) u_fwd (
            .src         (ex_src[i]),
            .mem_rd      (mem_rd),
            .mem_we      (mem_we),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .wb_we       (wb_we),
            .sel         (fwd_sel[i])
        );
    end

    // Present the select codes on the operand ports.
    always_comb begin
        fwd_a = fwd_sel[0];
        fwd_b = fwd_sel[1];
    end

    hz_load_use #(.AW(AW), .NSRC(NUM_SRC)) u_lu (
        .id_src     (id_src),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .hazard     (load_use)
    );

    hz_flow_ctrl u_flow (
        .load_use    (load_use),
        .br_taken    (mem_br_taken),
        .stall       (stall),
        .bubble_idex (bubble_idex),
        .flush_ifid  (flush_ifid),
        .flush_idex  (flush_idex),
        .flush_exmem (flush_exmem),
        .pc_redirect (pc_redirect)
    );
endmodule

// File: rtl/hazard_ctrl_chk.sv
`timescale 1ns/1ps
// Port-level checker for hazard_ctrl. The block has no clock, so every rule is
// an immediate assertion that is evaluated whenever its inputs change.
module hazard_ctrl_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic          mem_is_load,
    input logic [AW-1:0] wb_rd,
    input logic          wb_we,
    input logic          mem_br_taken,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          stall,
    input logic          bubble_idex,
    input logic          flush_ifid,
    input logic          flush_idex,
    input logic          flush_exmem,
    input logic          pc_redirect
);
    // Select legality and producer consistency for both operands.
    always_comb begin
        p_fwd_code_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("illegal bypass code");
        p_mem_src_r1: assert (fwd_a != 2'b10 || (mem_we && mem_rd == ex_rs1 && mem_rd != '0))
            else $error("operand a bypass from invalid memory-stage producer");
        p_mem_src_b_r1: assert (fwd_b != 2'b10 || (mem_we && mem_rd == ex_rs2 && mem_rd != '0))
            else $error("operand b bypass from invalid memory-stage producer");
        p_wb_src_r2: assert (fwd_a != 2'b01 || (wb_we && wb_rd == ex_rs1 && wb_rd != '0))
            else $error("operand a bypass from invalid write-back producer");
        p_wb_src_b_r2: assert (fwd_b != 2'b01 || (wb_we && wb_rd == ex_rs2 && wb_rd != '0))
            else $error("operand b bypass from invalid write-back producer");
        p_no_load_src_r4: assert (!mem_is_load || (fwd_a != 2'b10 && fwd_b != 2'b10))
            else $error("load in memory stage used as bypass source");
        p_zero_src_r5: assert ((ex_rs1 != '0 || fwd_a == 2'b00) && (ex_rs2 != '0 || fwd_b == 2'b00))
            else $error("register 0 bypassed");
    end

    // Flow-control consistency between hold, bubble and flush.
    always_comb begin
        p_hold_pair_r6: assert (stall == bubble_idex)
            else $error("stall and bubble disagree");
        p_flush_wins_r10: assert (!mem_br_taken || (!stall && !bubble_idex))
            else $error("hold raised during a redirect");
        p_flush_set_r9: assert ((flush_ifid == pc_redirect) && (flush_idex == pc_redirect) &&
                                (flush_exmem == pc_redirect))
            else $error("flush outputs disagree");
    end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.AW(AW)) u_chk (
    .ex_rs1       (ex_rs1),
    .ex_rs2       (ex_rs2),
    .mem_rd       (mem_rd),
    .mem_we       (mem_we),
    .mem_is_load  (mem_is_load),
    .wb_rd        (wb_rd),
    .wb_we        (wb_we),
    .mem_br_taken (mem_br_taken),
    .fwd_a        (fwd_a),
    .fwd_b        (fwd_b),
    .stall        (stall),
    .bubble_idex  (bubble_idex),
    .flush_ifid   (flush_ifid),
    .flush_idex   (flush_idex),
    .flush_exmem  (flush_exmem),
    .pc_redirect  (pc_redirect)
);

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
// Sweeps a four-register subset over every control input of hazard_ctrl and
// compares each output with values worked out from the requirements.
module hazard_ctrl_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          ex_we, ex_is_load, mem_we, mem_is_load, wb_we, mem_br_taken;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble_idex, flush_ifid, flush_idex, flush_exmem, pc_redirect;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hazard_ctrl #(.AW(AW)) u_dut (.*);

    // Compare one value and log a failure line with the requirement tag.
    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected bypass code for one source (R1..R5).
    function automatic int exp_fwd(input int src);
        if (mem_we && !mem_is_load && mem_rd != 0 && int'(mem_rd) == src) return 2;
        if (wb_we && wb_rd != 0 && int'(wb_rd) == src) return 1;
        return 0;
    endfunction

    // Requirement tag for a bypass check on one source.
    function automatic string fwd_tag(input int src);
        bit mh = mem_we && mem_rd != 0 && int'(mem_rd) == src;
        bit wh = wb_we && wb_rd != 0 && int'(wb_rd) == src;
        if (mh && mem_is_load) return "R4";
        if (mh && wh) return "R3";
        if (mh) return "R1";
        if (wh) return "R2";
        return "R5";
    endfunction

    // Idle every input.
    task automatic idle();
        id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0;
        ex_rd = '0; mem_rd = '0; wb_rd = '0;
        ex_we = 1'b0; ex_is_load = 1'b0; mem_we = 1'b0; mem_is_load = 1'b0;
        wb_we = 1'b0; mem_br_taken = 1'b0;
    endtask

    initial begin
        idle();
        @(negedge clk);
        // Idle state: no bypass, no hold, no flush (R5, R9).
        chk("R5", "idle fwd_a", fwd_a, 0);
        chk("R5", "idle fwd_b", fwd_b, 0);
        chk("R5", "idle stall", stall, 0);
        chk("R9", "idle redirect", pc_redirect, 0);

        // Bypass sweep: ALU->ALU, load in memory stage, write-back producers.
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
        for (int mw = 0; mw < 2; mw++)
        for (int ml = 0; ml < 2; ml++)
        for (int w = 0; w < 4; w++)
        for (int ww = 0; ww < 2; ww++) begin
            @(posedge clk); #1;
            idle();
            ex_rs1 = AW'(a); ex_rs2 = AW'(b);
            mem_rd = AW'(m); mem_we = mw[0]; mem_is_load = ml[0];
            wb_rd = AW'(w); wb_we = ww[0];
            @(negedge clk);
            chk(fwd_tag(a), "fwd_a", fwd_a, exp_fwd(a));
            chk(fwd_tag(b), "fwd_b", fwd_b, exp_fwd(b));
            chk("R7", "stall with idle execute", stall, 0);
        end

        // Hold and flush sweep: load->use, load->independent, branch outcomes.
        for (int i1 = 0; i1 < 4; i1++)
        for (int i2 = 0; i2 < 4; i2++)
        for (int e = 0; e < 4; e++)
        for (int ew = 0; ew < 2; ew++)
        for (int el = 0; el < 2; el++)
        for (int w = 0; w < 4; w++)
        for (int tk = 0; tk < 2; tk++) begin
            bit lu;
            string tag;
            @(posedge clk); #1;
            idle();
            id_rs1 = AW'(i1); id_rs2 = AW'(i2);
            ex_rd = AW'(e); ex_we = ew[0]; ex_is_load = el[0];
            wb_rd = AW'(w); wb_we = 1'b1;
            mem_br_taken = tk[0];
            lu = el[0] && ew[0] && e != 0 && (e == i1 || e == i2);
            if (lu && tk != 0)                           tag = "R10";
            else if (lu)                                 tag = "R6";
            else if (!ew[0] || e == 0)                   tag = "R5";
            else if (e == i1 || e == i2)                 tag = "R7";
            else if (w != 0 && (w == i1 || w == i2))     tag = "R8";
            else                                         tag = "R7";
            @(negedge clk);
            chk(tag, "stall", stall, int'(lu && tk == 0));
            chk(tag, "bubble_idex", bubble_idex, int'(lu && tk == 0));
            chk("R9", "pc_redirect", pc_redirect, tk);
            chk("R9", "flush_ifid", flush_ifid, tk);
            chk("R9", "flush_idex", flush_idex, tk);
            chk("R9", "flush_exmem", flush_exmem, tk);
            chk("R1", "fwd_a unused", fwd_a, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule